// File: doc/BRIEF.md
# Bias sweep optimization controller

This controller picks a digital bias setting for an oscillator by trial. A start pulse captures a mode, a noise limit, an inclusive code window and a settle length. The controller then steps a 5-bit bias code upward through that window. The code selects one of 32 evenly spaced levels between two programmable rails, nominally 40 mV apart. For each code it waits for the analog side to settle, then asks an external predictor for a noise estimate. A lower estimate means less noise.

Two objectives are available. In minimum-noise mode the whole window is swept and the code with the smallest estimate is kept. In minimum-power mode the sweep stops at the first code whose estimate is within the limit, because that is the lowest bias that still meets the limit. If no code in the window meets the limit, the controller raises a fail flag and applies the quietest code it saw. Each start is independent of the runs before it, so software can run a fresh search after every frequency band change, and each band may end up with a different code.

Top module: `bias_sweep_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `dac_code_o` is 0 and `pred_req_o`, `done_o` and `fail_o` are low.
- R2: A start pulse in the idle or done state latches mode, limit, window and settle length. Later changes to these inputs have no effect on the run. The first code applied is the low bound, and each later code is one above the previous one. The sweep never goes above the high bound. If the low bound exceeds the high bound, only the low bound is evaluated.
- R3: After each new code is applied, `pred_req_o` rises exactly `settle_i + 1` cycles later, where `settle_i` is the value latched at start.
- R4: `pred_req_o` stays high, with `dac_code_o` unchanged, until the cycle in which `pred_vld_i` is high. A `pred_vld_i` pulse while `pred_req_o` is low is ignored.
- R5: With `mode_i` = 0 (minimum noise), every code in the window is evaluated. The result is the code with the smallest `pred_val_i`, and `fail_o` stays low.
- R6: When two codes return the same smallest estimate, the lower code is chosen.
- R7: With `mode_i` = 1 (minimum power), the first code whose estimate is less than or equal to `spec_i` becomes the result, `fail_o` stays low, and no further requests are issued.
- R8: In minimum-power mode, if no code meets the limit, `fail_o` goes high and the result is the code with the smallest estimate, with ties going to the lower code.
- R9: When the result is known, `done_o` goes high and stays high, and `dac_code_o` holds the result, until the next start. `done_o` is low in the cycle after a start is accepted.
- R10: A start pulse during a sweep is ignored.
- R11: Each run's result depends only on the estimates returned during that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle pulse that begins a search |
| mode_i | input | 1 | 0 = minimum noise, 1 = minimum power |
| spec_i | input | PRED_W | Noise limit for minimum-power mode |
| code_lo_i | input | CODE_W | First code of the window |
| code_hi_i | input | CODE_W | Last code of the window |
| settle_i | input | SETTLE_W | Extra settle cycles after each code change |
| pred_req_o | output | 1 | Request for an estimate at the applied code |
| pred_vld_i | input | 1 | Estimate valid |
| pred_val_i | input | PRED_W | Noise estimate, smaller is better |
| dac_code_o | output | CODE_W | Bias code driven to the DAC |
| done_o | output | 1 | Search finished and result applied |
| fail_o | output | 1 | No code met the limit (minimum-power mode) |

## Verification
The assertions assume that the predictor raises `pred_vld_i` for one cycle per request, with `pred_val_i` valid in that cycle. They also assume that reset is the only thing that interrupts a run. The bench models the predictor with a fixed two-cycle answer latency, and its estimates are computed from the applied code through a small set of profiles: V-shaped, falling, flat, and two-way tie. To exercise the ignore rules, the bench also injects stray valid pulses and stray start pulses only at moments that lie outside a request window or inside an active sweep.

// File: rtl/bsweep_pkg.sv
package bsweep_pkg;

    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_SETTLE = 2'd1,
        SW_WAIT   = 2'd2,
        SW_DONE   = 2'd3
    } sweep_state_e;

    localparam logic MODE_MIN_NOISE = 1'b0;
    localparam logic MODE_MIN_POWER = 1'b1;

endpackage

// File: rtl/bsweep_settle.sv
module bsweep_settle #(
    parameter int unsigned SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [SETTLE_W-1:0] len_i,
    output logic                expired_o
);

    logic [SETTLE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/bsweep_best.sv
module bsweep_best #(
    parameter int unsigned CODE_W = 5,
    parameter int unsigned PRED_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              upd_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [PRED_W-1:0] val_i,
    output logic              improves_o,
    output logic [CODE_W-1:0] best_code_o
);

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
        logic [PRED_W-1:0] val;
    } best_t;

    best_t best_d, best_q;

    // Strict less-than: an equal estimate at a later (higher) code never wins.
    assign improves_o = !best_q.valid || (val_i < best_q.val);

    always_comb begin
        best_d = best_q;
        if (clear_i) begin
            best_d.valid = 1'b0;
        end else if (upd_i && improves_o) begin
            best_d.valid = 1'b1;
            best_d.code  = code_i;
            best_d.val   = val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_q <= '0;
        end else begin
            best_q <= best_d;
        end
    end

    assign best_code_o = best_q.code;

    // R6
    best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        best_q.valid && !clear_i |=> best_q.val <= $past(best_q.val));

    // R6
    tie_keeps_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i && !clear_i && best_q.valid && (val_i == best_q.val)
        |=> best_q.code == $past(best_q.code));

endmodule

// File: rtl/bias_sweep_ctrl.sv
module bias_sweep_ctrl #(
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned PRED_W   = 10,
    parameter int unsigned SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                mode_i,
    input  logic [PRED_W-1:0]   spec_i,
    input  logic [CODE_W-1:0]   code_lo_i,
    input  logic [CODE_W-1:0]   code_hi_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic                pred_req_o,
    input  logic                pred_vld_i,
    input  logic [PRED_W-1:0]   pred_val_i,
    output logic [CODE_W-1:0]   dac_code_o,
    output logic                done_o,
    output logic                fail_o
);
    import bsweep_pkg::*;

    typedef struct packed {
        sweep_state_e        st;
        logic                mode;
        logic [PRED_W-1:0]   spec;
        logic [CODE_W-1:0]   lo;
        logic [CODE_W-1:0]   hi;
        logic [CODE_W-1:0]   code;
        logic [SETTLE_W-1:0] settle;
        logic                fail;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: SW_IDLE, default: '0};

    ctl_t ctl_d, ctl_q;

    logic                settle_load;
    logic [SETTLE_W-1:0] settle_len;
    logic                settle_expired;
    logic                start_acc;
    logic                sample_acc;
    logic                sample_improves;
    logic [CODE_W-1:0]   best_code;

    bsweep_settle #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (settle_load),
        .len_i     (settle_len),
        .expired_o (settle_expired)
    );

    bsweep_best #(.CODE_W(CODE_W), .PRED_W(PRED_W)) u_best (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_acc),
        .upd_i       (sample_acc),
        .code_i      (ctl_q.code),
        .val_i       (pred_val_i),
        .improves_o  (sample_improves),
        .best_code_o (best_code)
    );

    always_comb begin
        ctl_d       = ctl_q;
        settle_load = 1'b0;
        start_acc   = 1'b0;
        sample_acc  = 1'b0;
        settle_len  = ctl_q.settle;
        case (ctl_q.st)
            SW_IDLE, SW_DONE: begin
                if (start_i) begin
                    start_acc    = 1'b1;
                    settle_load  = 1'b1;
                    settle_len   = settle_i;
                    ctl_d.mode   = mode_i;
                    ctl_d.spec   = spec_i;
                    ctl_d.lo     = code_lo_i;
                    ctl_d.hi     = code_hi_i;
                    ctl_d.settle = settle_i;
                    ctl_d.code   = code_lo_i;
                    ctl_d.fail   = 1'b0;
                    ctl_d.st     = SW_SETTLE;
                end
            end
            SW_SETTLE: begin
                if (settle_expired) begin
                    ctl_d.st = SW_WAIT;
                end
            end
            SW_WAIT: begin
                if (pred_vld_i) begin
                    sample_acc = 1'b1;
                    if ((ctl_q.mode == MODE_MIN_POWER) && (pred_val_i <= ctl_q.spec)) begin
                        ctl_d.st = SW_DONE;
                    end else if (ctl_q.code >= ctl_q.hi) begin
                        ctl_d.st   = SW_DONE;
                        ctl_d.code = sample_improves ? ctl_q.code : best_code;
                        ctl_d.fail = (ctl_q.mode == MODE_MIN_POWER);
                    end else begin
                        ctl_d.code  = ctl_q.code + 1'b1;
                        ctl_d.st    = SW_SETTLE;
                        settle_load = 1'b1;
                    end
                end
            end
            default: ctl_d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pred_req_o = (ctl_q.st == SW_WAIT);
    assign done_o     = (ctl_q.st == SW_DONE);
    assign fail_o     = ctl_q.fail;
    assign dac_code_o = ctl_q.code;

    // R2
    code_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == SW_SETTLE || ctl_q.st == SW_WAIT)
        |-> (ctl_q.code >= ctl_q.lo) && ((ctl_q.code <= ctl_q.hi) || (ctl_q.code == ctl_q.lo)));

    // R3
    no_req_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code_o != $past(dac_code_o)) |-> !pred_req_o);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req_o && !pred_vld_i |=> pred_req_o && $stable(dac_code_o));

    // R7
    power_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req_o && pred_vld_i && (ctl_q.mode == MODE_MIN_POWER) && (pred_val_i <= ctl_q.spec)
        |=> done_o && !fail_o && $stable(dac_code_o));

    // R8
    fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(dac_code_o) && $stable(fail_o));

endmodule

// File: tb/tb_bias_sweep_ctrl.sv
module tb_bias_sweep_ctrl;

    localparam int CODE_W   = 5;
    localparam int PRED_W   = 10;
    localparam int SETTLE_W = 4;

    typedef struct packed {
        logic                mode;
        logic [CODE_W-1:0]   lo;
        logic [CODE_W-1:0]   hi;
        logic [SETTLE_W-1:0] settle;
        logic [PRED_W-1:0]   spec;
        logic [2:0]          prof;
        logic [CODE_W-1:0]   exp_code;
        logic                exp_fail;
        logic [5:0]          exp_reqs;
        logic                stray;
    } vec_t;

    // mode lo hi settle spec prof | exp_code exp_fail exp_reqs | stray
    localparam vec_t VECS [12] = '{
        '{1'b0, 5'd0,  5'd31, 4'd2,  10'd0,   3'd0, 5'd12, 1'b0, 6'd32, 1'b1},
        '{1'b0, 5'd3,  5'd9,  4'd0,  10'd0,   3'd0, 5'd9,  1'b0, 6'd7,  1'b0},
        '{1'b0, 5'd5,  5'd20, 4'd1,  10'd0,   3'd2, 5'd5,  1'b0, 6'd16, 1'b0},
        '{1'b0, 5'd0,  5'd31, 4'd3,  10'd0,   3'd3, 5'd8,  1'b0, 6'd32, 1'b0},
        '{1'b1, 5'd0,  5'd31, 4'd1,  10'd30,  3'd0, 5'd7,  1'b0, 6'd8,  1'b1},
        '{1'b1, 5'd0,  5'd31, 4'd0,  10'd29,  3'd0, 5'd8,  1'b0, 6'd9,  1'b0},
        '{1'b1, 5'd10, 5'd31, 4'd2,  10'd5,   3'd0, 5'd12, 1'b1, 6'd22, 1'b0},
        '{1'b1, 5'd0,  5'd31, 4'd1,  10'd100, 3'd1, 5'd20, 1'b0, 6'd21, 1'b0},
        '{1'b0, 5'd7,  5'd7,  4'd5,  10'd0,   3'd1, 5'd7,  1'b0, 6'd1,  1'b0},
        '{1'b0, 5'd9,  5'd4,  4'd0,  10'd0,   3'd0, 5'd9,  1'b0, 6'd1,  1'b0},
        '{1'b1, 5'd0,  5'd31, 4'd0,  10'd0,   3'd1, 5'd31, 1'b1, 6'd32, 1'b0},
        '{1'b0, 5'd0,  5'd31, 4'd15, 10'd0,   3'd1, 5'd31, 1'b0, 6'd32, 1'b0}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic                mode_i = 1'b0;
    logic [PRED_W-1:0]   spec_i = '0;
    logic [CODE_W-1:0]   code_lo_i = '0;
    logic [CODE_W-1:0]   code_hi_i = '0;
    logic [SETTLE_W-1:0] settle_i = '0;
    logic                pred_vld_i = 1'b0;
    logic [PRED_W-1:0]   pred_val_i = '0;
    logic                pred_req_o;
    logic [CODE_W-1:0]   dac_code_o;
    logic                done_o;
    logic                fail_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bias_sweep_ctrl #(.CODE_W(CODE_W), .PRED_W(PRED_W), .SETTLE_W(SETTLE_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .spec_i     (spec_i),
        .code_lo_i  (code_lo_i),
        .code_hi_i  (code_hi_i),
        .settle_i   (settle_i),
        .pred_req_o (pred_req_o),
        .pred_vld_i (pred_vld_i),
        .pred_val_i (pred_val_i),
        .dac_code_o (dac_code_o),
        .done_o     (done_o),
        .fail_o     (fail_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pval(input int prof, input int c);
        case (prof)
            0:       pval = ((c > 12) ? (c - 12) : (12 - c)) * 4 + 10;
            1:       pval = 200 - 5 * c;
            2:       pval = 50;
            default: pval = (c <= 8) ? (8 - c) * 3 + 40 : (c - 9) * 3 + 40;
        endcase
    endfunction

    task automatic run(input vec_t v, output int reqs);
        int  cyc;
        int  lat;
        bit  seen_done;
        string tag;
        @(negedge clk);
        mode_i = v.mode; code_lo_i = v.lo; code_hi_i = v.hi;
        settle_i = v.settle; spec_i = v.spec; start_i = 1'b1;
        cyc = -1; lat = -1; reqs = 0; seen_done = 1'b0;
        for (int it = 0; it < 4000 && !seen_done; it++) begin
            @(negedge clk);
            start_i = 1'b0; pred_vld_i = 1'b0; cyc++;
            if (it == 0) chk(!done_o, "R9 done low after start", done_o, 0);
            if (done_o) begin
                seen_done = 1'b1;
            end else if (lat < 0 && pred_req_o) begin
                chk(cyc == int'(v.settle) + 1, "R3 settle gap", cyc, int'(v.settle) + 1);
                chk(int'(dac_code_o) == int'(v.lo) + reqs, "R2 ascending code", dac_code_o, int'(v.lo) + reqs);
                reqs++; lat = 2;
                if (v.stray && reqs == 3) begin
                    start_i = 1'b1; mode_i = ~v.mode; code_lo_i = v.lo + 5'd3; spec_i = '1;
                end
            end else if (lat > 0) begin
                chk(pred_req_o, "R4 request held", pred_req_o, 1);
                if (lat == 1) begin
                    pred_vld_i = 1'b1;
                    pred_val_i = PRED_W'(pval(int'(v.prof), int'(dac_code_o)));
                    cyc = -1; lat = -1;
                end else begin
                    lat--;
                end
            end else if (v.stray && cyc == 0) begin
                pred_vld_i = 1'b1; pred_val_i = '0;
            end
        end
        chk(seen_done, "R9 run completes", seen_done, 1);
        if (v.exp_fail) tag = "R8 fallback code";
        else if (v.prof == 3'd2 || v.prof == 3'd3) tag = "R6 tie to lower code";
        else if (v.mode) tag = "R7 first passing code";
        else tag = "R5 lowest estimate code";
        chk(dac_code_o == v.exp_code, tag, dac_code_o, v.exp_code);
        chk(fail_o == v.exp_fail, "R8 fail flag", fail_o, v.exp_fail);
        chk(reqs == int'(v.exp_reqs), v.mode ? "R7 request count" : "R5 request count", reqs, v.exp_reqs);
        if (v.stray) begin
            chk(dac_code_o == v.exp_code, "R10 start ignored mid-sweep", dac_code_o, v.exp_code);
            chk(dac_code_o == v.exp_code, "R4 stray valid ignored", dac_code_o, v.exp_code);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        // R1: during and after reset
        repeat (3) @(negedge clk);
        chk(dac_code_o == 0 && !pred_req_o && !done_o && !fail_o, "R1 outputs in reset", dac_code_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dac_code_o == 0 && !pred_req_o && !done_o && !fail_o, "R1 outputs after reset", dac_code_o, 0);

        for (int i = 0; i < 12; i++) begin
            run(VECS[i], n);
        end

        // R9: result holds, stray valid in done state has no effect (R4)
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            pred_vld_i = (k == 3); pred_val_i = '0;
        end
        @(negedge clk);
        pred_vld_i = 1'b0;
        chk(done_o && dac_code_o == 5'd31 && !fail_o, "R9 result held", dac_code_o, 31);
        chk(!pred_req_o, "R4 no request in done", pred_req_o, 0);

        // R11: falling profile first, then flat window; old best must not carry over
        run(VECS[11], n);
        run(VECS[2], n);
        chk(dac_code_o == 5'd5, "R11 independent run", dac_code_o, 5);

        // R1: reset in the middle of a sweep
        @(negedge clk);
        mode_i = 1'b0; code_lo_i = 5'd4; code_hi_i = 5'd31; settle_i = 4'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(dac_code_o == 0 && !pred_req_o && !done_o && !fail_o, "R1 reset mid-sweep", dac_code_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!done_o && !pred_req_o, "R1 idle after reset", done_o, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule